// File: doc/BRIEF.md
# Parallel-Port Status Edge Interrupt Controller

This block watches six status lines of a parallel port (strobe, acknowledge, busy, paper-end, select and error) and combines them into one interrupt request. Each line has its own status flag, which stays set once set. Each line also has an enable bit. Four of the lines have a bit that selects which edge is detected. The lines arrive from outside the clock domain and are resynchronised inside the block.

Software sees one 16-bit register. The status flags sit in the upper six bits and are cleared by writing one to them. The lower ten bits hold the enables and the edge selects, and a write replaces them. The interrupt output is high while any status flag is set.

Top module: `pp_irq_ctrl`

## Requirements
- R1: `rd_data` always shows the register. Bits 15..10 are the status flags for strobe, acknowledge, busy, paper-end, select and error, in that order. Bits 9..0 are the control bits as last written.
- R2: A write clears every status flag whose `wr_data` bit is 1. A status flag whose `wr_data` bit is 0 is left unchanged.
- R3: A set status flag stays set until it is cleared by a write.
- R4: Strobe (enable at bit 9) and acknowledge (enable at bit 8) set their flags only on a rising edge of their line. A falling edge has no effect on them.
- R5: Busy, paper-end, select and error take their edge select from bits 7, 5, 3 and 1 and their enable from bits 6, 4, 2 and 0. An edge select of 1 detects the rising edge and 0 detects the falling edge.
- R6: An edge on a line whose enable bit is 0 does not set its flag.
- R7: `irq` is 1 exactly when at least one status flag is set.
- R8: Each line passes through a synchroniser of `SYNC_STAGES` flops before edge detection. With the default of 2, a change captured at clock edge k shows in the status flags after clock edge k+2.
- R9: If an edge is detected in the same cycle as a write that clears the same flag, the flag ends up set.
- R10: Reset clears all status flags, enables and edge selects, and `irq` is 0.
- R11: A write replaces all ten control bits in the next cycle. Edge detection in the cycle of the write uses the control bits from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data: bits 15..10 clear status, bits 9..0 load control |
| rd_data | output | 16 | Register contents |
| sig_in | input | 6 | Asynchronous lines: [5] strobe, [4] acknowledge, [3] busy, [2] paper-end, [1] select, [0] error |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. This makes the exact three-edge path from a line change to a visible flag measurable cycle by cycle. It also lets a clearing write be lined up with the cycle in which an edge is detected. A behavioural model delays the sampled lines through a queue as deep as the synchroniser, so the same model would follow a deeper setting. Directed cases cover each edge select, disabled lines and the set-over-clear collision. A long stretch of random line activity and random writes is then compared against the model on every clock.

// File: rtl/pp_irq_ctrl.sv
module pp_irq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic [5:0]  sig_in,
  output logic        irq
);
  localparam int NSRC = 6;

  logic [NSRC-1:0] sync_q [SYNC_STAGES];
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] status_q;
  logic [9:0]      ctrl_q;
  logic [NSRC-1:0] cur, en, rise_sel, hit;

  assign cur      = sync_q[SYNC_STAGES-1];
  assign en       = {ctrl_q[9], ctrl_q[8], ctrl_q[6], ctrl_q[4], ctrl_q[2], ctrl_q[0]};
  assign rise_sel = {2'b11, ctrl_q[7], ctrl_q[5], ctrl_q[3], ctrl_q[1]};
  assign hit      = en & ((rise_sel & cur & ~prev_q) | (~rise_sel & ~cur & prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= sig_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ctrl_q   <= '0;
    end else begin
      status_q <= (status_q & ~(wr_en ? wr_data[15:10] : 6'b0)) | hit;
      if (wr_en) ctrl_q <= wr_data[9:0];
    end
  end

  assign rd_data = {status_q, ctrl_q};
  assign irq     = |status_q;
endmodule

module pp_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        irq,
  input logic [5:0]  hit
);
  p_irq_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[15:10] != 6'b0));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit == 6'b0) |=> ((rd_data[15:10] & $past(wr_data[15:10])) == 6'b0));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rd_data[15:10] & $past(rd_data[15:10])) == $past(rd_data[15:10])));

  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[10]) |-> $past(rd_data[0]));

  p_ctrl_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[9:0] == $past(wr_data[9:0]));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != 6'b0) |=> ((rd_data[15:10] & $past(hit)) == $past(hit)));
endmodule

bind pp_irq_ctrl pp_irq_ctrl_chk chk_i (.*);

// File: tb/pp_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pp_irq_ctrl_tb_top;
  localparam int STG = 2;
  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [15:0] wr_data = '0, rd_data;
  logic [5:0] sig_in = '0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pp_irq_ctrl #(.SYNC_STAGES(STG)) dut_i (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .sig_in, .irq);

  // behavioural reference
  logic [5:0] m_st;
  logic [9:0] m_ct;
  logic [5:0] hq[$];

  function automatic int en_pos(int i);
    case (i) 5: return 9; 4: return 8; 3: return 6; 2: return 4; 1: return 2; default: return 0; endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_ct = '0; hq.delete();
      for (int i = 0; i <= STG; i++) hq.push_back(6'b0);
    end else begin
      logic [5:0] c, p, s;
      c = hq[STG-1]; p = hq[STG]; s = '0;
      for (int i = 0; i < 6; i++) begin
        bit up;
        up = (i >= 4) ? 1'b1 : m_ct[en_pos(i)+1];
        if (m_ct[en_pos(i)] && ((up && c[i] && !p[i]) || (!up && !c[i] && p[i]))) s[i] = 1'b1;
      end
      if (wr_en) begin
        m_st = m_st & ~wr_data[15:10];
        m_ct = wr_data[9:0];
      end
      m_st = m_st | s;
      hq.push_front(sig_in);
      void'(hq.pop_back());
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    nchk++;
    if (rd_data !== {m_st, m_ct}) begin
      nerr++; $display("FAIL R1 model rd_data act=%h exp=%h", rd_data, {m_st, m_ct});
    end
    nchk++;
    if (irq !== (m_st != 0)) begin
      nerr++; $display("FAIL R7 model irq act=%b exp=%b", irq, (m_st != 0));
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask

  initial begin
    tick(2);
    chk(rd_data, 16'h0000, "R10 reset register");
    chk({15'b0, irq}, 16'h0, "R10 reset irq");
    rst_n = 1; tick();
    wr(16'h03FF);
    chk(rd_data, 16'h03FF, "R11 control load");
    sig_in = 6'b100000; tick(2);
    chk(rd_data, 16'h03FF, "R8 not yet through synchroniser");
    tick();
    chk(rd_data, 16'h83FF, "R4 strobe rising sets");
    chk({15'b0, irq}, 16'h1, "R7 irq high");
    tick(5);
    chk(rd_data, 16'h83FF, "R3 sticky");
    wr(16'h83FF);
    chk(rd_data, 16'h03FF, "R2 clear by one");
    chk({15'b0, irq}, 16'h0, "R7 irq low");
    sig_in = 6'b000000; tick(4);
    chk(rd_data, 16'h03FF, "R4 strobe falling ignored");
    wr(16'h037F);
    sig_in = 6'b001000; tick(4);
    chk(rd_data, 16'h037F, "R5 busy rising ignored with falling select");
    sig_in = 6'b000000; tick(4);
    chk(rd_data, 16'h237F, "R5 busy falling sets");
    wr(16'h037F);
    chk(rd_data, 16'h237F, "R2 zero leaves flag");
    wr(16'h237F);
    chk(rd_data, 16'h037F, "R2 clear busy");
    wr(16'h0000);
    sig_in = 6'b000001; tick(4);
    sig_in = 6'b000000; tick(4);
    chk(rd_data, 16'h0000, "R6 disabled source");
    wr(16'h0003);
    sig_in = 6'b000001; tick(2);
    wr(16'h0403);
    chk(rd_data, 16'h0403, "R9 set wins over clear");
    wr(16'h0403);
    chk(rd_data, 16'h0003, "R2 clear after collision");
    sig_in = 6'b000000; tick(4);
    for (int k = 0; k < 3000; k++) begin
      sig_in = 6'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        wr_en = 1; wr_data = 16'($urandom);
      end else wr_en = 0;
      tick();
    end
    wr_en = 0;
    tick(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule